// File: doc/BRIEF.md
# Keyed Configuration Index/Data Port

This block is a configuration register file reached through a two-address I/O window. Software writes a register number to the index port (address bit 0) and then reads or writes the chosen register through the data port (address bit 1). The window is closed after reset. It opens only when the enter key 0x87 is written to the index port on two index writes in a row. Writing the exit key 0xAA to the index port closes it again. While the window is closed, nothing in the register file can be changed and every read returns 0xFF.

Registers below 0x30 are global. They are a logical-device select register at 0x07, a 16-bit device ID, a revision byte and a 16-bit manufacturer ID. Registers from 0x30 upward are banked. Each logical device has its own enable register at 0x30 and its own window of `BANK_REGS` registers starting at `BANK_BASE`, and the select register decides which bank the data port reaches. One logical device, `WDG_LDN`, is wired to an attached watchdog. Its enable bit and its bank registers are driven out on dedicated pins at all times. Decoding the base address on the system bus is done outside this block.

The key sequence is tracked by a three-state machine:
- `ST_LOCKED`: the reset state.
- `ST_ARMED`: one enter key has been seen.
- `ST_OPEN`: the window is open.

The transitions are:
- `LOCKED->ARMED`: an index write of 0x87.
- `ARMED->OPEN`: an index write of 0x87.
- `ARMED->LOCKED`: an index write of any other value, or a data-port write.
- `OPEN->LOCKED`: an index write of 0xAA.

Any other bus activity leaves the state unchanged.

Top module: `kcp_config_port`

## Requirements
- R1: After reset the state is locked. Data-port reads and index-port reads return 0xFF. The select register is 0x00 and every bank register is 0x00, so `wdg_enable` is 0.
- R2: The window opens only after two consecutive index writes of 0x87. After a single 0x87, reads still return 0xFF. An index write of any other value, or a data-port write, between the two keys discards the first key.
- R3: An index write of 0xAA while open locks the port, and later reads return 0xFF. The index register keeps its previous value and still holds it after the next unlock.
- R4: While the port is not open, data-port writes change no register and index writes other than keys do not load the index register.
- R5: While open, an index write loads the register number, and an index-port read returns it. The read data appears on `io_rdata` in the cycle after the read strobe and holds until the next read strobe.
- R6: Register 0x07 is an 8-bit read/write logical-device select register.
- R7: Register 0x20 reads `DEV_ID[15:8]`, 0x21 reads `DEV_ID[7:0]`, 0x22 reads `DEV_REV`, 0x23 reads `MFR_ID[15:8]` and 0x24 reads `MFR_ID[7:0]`, with `MFR_ID` defaulting to 0x1934. Writes to these registers are ignored.
- R8: Register 0x30 and registers `BANK_BASE` to `BANK_BASE+BANK_REGS-1` are stored separately for each logical device 0 to `NUM_LDN-1`, and the current select value chooses the device. When the select value is `NUM_LDN` or higher, these registers read 0x00 and writes to them are dropped.
- R9: Every other register number reads 0x00 and ignores writes.
- R10: `wdg_enable` is bit 0 of register 0x30 of device `WDG_LDN`. Byte k of `wdg_regs` (bits 8k+7 to 8k) is register `BANK_BASE+k` of that device. Both follow writes in the next cycle and hold whatever the lock state is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 1 | 0 selects the index port, 1 selects the data port |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe, one cycle per read |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, registered on the read strobe |
| wdg_enable | output | 1 | Enable bit of the watchdog's logical device |
| wdg_regs | output | 8*BANK_REGS | Bank registers of the watchdog's logical device |

## Verification
The bench builds the block with `NUM_LDN=4`, `WDG_LDN=2`, `BANK_BASE=0xF4` and `BANK_REGS=4`. This makes select values 4 and 5 reachable, so the dropped-write and read-as-zero behaviour of out-of-range devices can be checked next to four real banks. It first writes an arithmetic pattern to every register number except the exit key, for six select values. It then reads all of them back, which covers the global registers, the ID registers, bank isolation and unimplemented numbers in one sweep. The directed key sequences before the sweep cover the arm/disarm paths of the state machine and the retention of the index register across a lock.

// File: rtl/kcp_pkg.sv
package kcp_pkg;

    typedef enum logic [1:0] {
        ST_LOCKED = 2'd0,
        ST_ARMED  = 2'd1,
        ST_OPEN   = 2'd2
    } key_state_t;

    localparam logic [7:0] KEY_ENTER    = 8'h87;
    localparam logic [7:0] KEY_EXIT     = 8'hAA;

    localparam logic [7:0] IDX_SELECT   = 8'h07;
    localparam logic [7:0] IDX_DEVID_HI = 8'h20;
    localparam logic [7:0] IDX_DEVID_LO = 8'h21;
    localparam logic [7:0] IDX_REV      = 8'h22;
    localparam logic [7:0] IDX_MFR_HI   = 8'h23;
    localparam logic [7:0] IDX_MFR_LO   = 8'h24;
    localparam logic [7:0] IDX_DEV_EN   = 8'h30;

    localparam logic [7:0] LOCKED_READ  = 8'hFF;

endpackage

// File: rtl/kcp_unlock_fsm.sv
module kcp_unlock_fsm
    import kcp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic       data_wr,
    input  logic [7:0] wdata,
    output logic       open
);

    key_state_t state_q;
    key_state_t state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LOCKED;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED: begin
                if (idx_wr && wdata == KEY_ENTER) begin
                    state_d = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (idx_wr) begin
                    state_d = (wdata == KEY_ENTER) ? ST_OPEN : ST_LOCKED;
                end else if (data_wr) begin
                    state_d = ST_LOCKED;
                end
            end
            ST_OPEN: begin
                if (idx_wr && wdata == KEY_EXIT) begin
                    state_d = ST_LOCKED;
                end
            end
            default: state_d = ST_LOCKED;
        endcase
    end

    // Output logic
    always_comb begin
        open = (state_q == ST_OPEN);
    end

    // R2: the open state is only reached from armed on a second enter key
    assert_open_after_two_keys_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPEN && $past(state_q) != ST_OPEN) |->
            ($past(state_q) == ST_ARMED && $past(idx_wr) && $past(wdata) == KEY_ENTER));

    // R3: the exit key always locks
    assert_exit_key_locks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPEN && idx_wr && wdata == KEY_EXIT) |=> (state_q == ST_LOCKED));

    // R2: a data write while armed discards the first key
    assert_data_write_disarms_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && data_wr && !idx_wr) |=> (state_q == ST_LOCKED));

endmodule

// File: rtl/kcp_global_regs.sv
module kcp_global_regs
    import kcp_pkg::*;
#(
    parameter logic [15:0] DEV_ID  = 16'h5A21,
    parameter logic [7:0]  DEV_REV = 8'h03,
    parameter logic [15:0] MFR_ID  = 16'h1934
)(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] index,
    input  logic [7:0] wdata,
    output logic [7:0] select,
    output logic [7:0] rdata
);

    logic [7:0] select_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            select_q <= 8'h00;
        end else if (wr_en && index == IDX_SELECT) begin
            select_q <= wdata;
        end
    end

    assign select = select_q;

    always_comb begin
        unique case (index)
            IDX_SELECT:   rdata = select_q;
            IDX_DEVID_HI: rdata = DEV_ID[15:8];
            IDX_DEVID_LO: rdata = DEV_ID[7:0];
            IDX_REV:      rdata = DEV_REV;
            IDX_MFR_HI:   rdata = MFR_ID[15:8];
            IDX_MFR_LO:   rdata = MFR_ID[7:0];
            default:      rdata = 8'h00;
        endcase
    end

    // R6: a write to the select register lands one cycle later
    assert_select_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && index == IDX_SELECT) |=> (select == $past(wdata)));

    // R6: nothing but a select write moves the select register
    assert_select_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && index == IDX_SELECT) |=> $stable(select));

endmodule

// File: rtl/kcp_device_bank.sv
module kcp_device_bank
    import kcp_pkg::*;
#(
    parameter int         NUM_LDN   = 8,
    parameter logic [7:0] BANK_BASE = 8'hF0,
    parameter int         BANK_REGS = 8,
    parameter int         WDG_LDN   = 7
)(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [7:0]             index,
    input  logic [7:0]             select,
    input  logic [7:0]             wdata,
    output logic [7:0]             rdata,
    output logic                   wdg_enable,
    output logic [BANK_REGS*8-1:0] wdg_regs
);

    logic [NUM_LDN-1:0][7:0]                 en_all;
    logic [NUM_LDN-1:0][BANK_REGS-1:0][7:0]  bank_all;
    logic [BANK_REGS-1:0]                    slot_hit;
    logic                                    en_hit;

    assign en_hit = (index == IDX_DEV_EN);

    for (genvar k = 0; k < BANK_REGS; k++) begin : g_slot
        assign slot_hit[k] = (index == BANK_BASE + 8'(k));
    end

    for (genvar g = 0; g < NUM_LDN; g++) begin : g_ldn
        logic                      dev_wr;
        logic [7:0]                en_q;
        logic [BANK_REGS-1:0][7:0] regs_q;

        assign dev_wr = wr_en && (select == 8'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q   <= 8'h00;
                regs_q <= '0;
            end else if (dev_wr) begin
                if (en_hit) begin
                    en_q <= wdata;
                end
                for (int k = 0; k < BANK_REGS; k++) begin
                    if (slot_hit[k]) begin
                        regs_q[k] <= wdata;
                    end
                end
            end
        end

        assign en_all[g]   = en_q;
        assign bank_all[g] = regs_q;
    end

    always_comb begin
        rdata = 8'h00;
        for (int g = 0; g < NUM_LDN; g++) begin
            if (select == 8'(g)) begin
                if (en_hit) begin
                    rdata = en_all[g];
                end
                for (int k = 0; k < BANK_REGS; k++) begin
                    if (slot_hit[k]) begin
                        rdata = bank_all[g][k];
                    end
                end
            end
        end
    end

    assign wdg_enable = en_all[WDG_LDN][0];
    assign wdg_regs   = bank_all[WDG_LDN];

    // R10: a write to the watchdog device's enable register shows on wdg_enable next cycle
    assert_wdg_enable_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && en_hit && select == 8'(WDG_LDN)) |=> (wdg_enable == $past(wdata[0])));

    // R10: writes aimed at another device leave the watchdog outputs alone
    assert_wdg_isolated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (select != 8'(WDG_LDN)) |=> ($stable(wdg_enable) && $stable(wdg_regs)));

endmodule

// File: rtl/kcp_config_port.sv
module kcp_config_port
    import kcp_pkg::*;
#(
    parameter int          NUM_LDN   = 8,
    parameter int          WDG_LDN   = 7,
    parameter logic [7:0]  BANK_BASE = 8'hF0,
    parameter int          BANK_REGS = 8,
    parameter logic [15:0] DEV_ID    = 16'h5A21,
    parameter logic [7:0]  DEV_REV   = 8'h03,
    parameter logic [15:0] MFR_ID    = 16'h1934
)(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   io_addr,
    input  logic                   io_wr,
    input  logic                   io_rd,
    input  logic [7:0]             io_wdata,
    output logic [7:0]             io_rdata,
    output logic                   wdg_enable,
    output logic [BANK_REGS*8-1:0] wdg_regs
);

    logic       idx_wr;
    logic       data_wr;
    logic       open;
    logic       reg_wr;
    logic [7:0] index_q;
    logic [7:0] select;
    logic [7:0] glob_rdata;
    logic [7:0] bank_rdata;
    logic [7:0] reg_rdata;
    logic [7:0] rdata_q;

    assign idx_wr  = io_wr && !io_addr;
    assign data_wr = io_wr && io_addr;
    assign reg_wr  = data_wr && open;

    kcp_unlock_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx_wr  (idx_wr),
        .data_wr (data_wr),
        .wdata   (io_wdata),
        .open    (open)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index_q <= 8'h00;
        end else if (idx_wr && open && io_wdata != KEY_EXIT) begin
            index_q <= io_wdata;
        end
    end

    kcp_global_regs #(
        .DEV_ID  (DEV_ID),
        .DEV_REV (DEV_REV),
        .MFR_ID  (MFR_ID)
    ) u_glob (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr),
        .index  (index_q),
        .wdata  (io_wdata),
        .select (select),
        .rdata  (glob_rdata)
    );

    kcp_device_bank #(
        .NUM_LDN   (NUM_LDN),
        .BANK_BASE (BANK_BASE),
        .BANK_REGS (BANK_REGS),
        .WDG_LDN   (WDG_LDN)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr),
        .index      (index_q),
        .select     (select),
        .wdata      (io_wdata),
        .rdata      (bank_rdata),
        .wdg_enable (wdg_enable),
        .wdg_regs   (wdg_regs)
    );

    assign reg_rdata = (index_q < IDX_DEV_EN) ? glob_rdata : bank_rdata;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= LOCKED_READ;
        end else if (io_rd) begin
            if (!open) begin
                rdata_q <= LOCKED_READ;
            end else if (!io_addr) begin
                rdata_q <= index_q;
            end else begin
                rdata_q <= reg_rdata;
            end
        end
    end

    assign io_rdata = rdata_q;

    // R4: a closed window reads 0xFF
    assert_locked_reads_ff_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !open) |=> (io_rdata == LOCKED_READ));

    // R4: the select register cannot move while the window is closed
    assert_locked_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !open |=> $stable(select));

    // R5: read data holds between read strobes
    assert_rdata_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |=> $stable(io_rdata));

endmodule

// File: tb/tb_kcp_config_port.sv
module tb_kcp_config_port;

    localparam int          NUM_LDN   = 4;
    localparam int          WDG_LDN   = 2;
    localparam logic [7:0]  BANK_BASE = 8'hF4;
    localparam int          BANK_REGS = 4;
    localparam logic [15:0] DEV_ID    = 16'h5A21;
    localparam logic [7:0]  DEV_REV   = 8'h03;
    localparam int          NSEL      = 6;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   io_addr = 1'b0;
    logic                   io_wr = 1'b0;
    logic                   io_rd = 1'b0;
    logic [7:0]             io_wdata = 8'h00;
    logic [7:0]             io_rdata;
    logic                   wdg_enable;
    logic [BANK_REGS*8-1:0] wdg_regs;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    kcp_config_port #(
        .NUM_LDN   (NUM_LDN),
        .WDG_LDN   (WDG_LDN),
        .BANK_BASE (BANK_BASE),
        .BANK_REGS (BANK_REGS),
        .DEV_ID    (DEV_ID),
        .DEV_REV   (DEV_REV)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .io_addr    (io_addr),
        .io_wr      (io_wr),
        .io_rd      (io_rd),
        .io_wdata   (io_wdata),
        .io_rdata   (io_rdata),
        .wdg_enable (wdg_enable),
        .wdg_regs   (wdg_regs)
    );

    function automatic logic [7:0] pat(int s, int i);
        return 8'((s * 29 + i * 7 + 3) & 255);
    endfunction

    function automatic logic [7:0] expect_reg(int s, int i);
        if (i == 8'h07) return 8'(s);
        if (i == 8'h20) return DEV_ID[15:8];
        if (i == 8'h21) return DEV_ID[7:0];
        if (i == 8'h22) return DEV_REV;
        if (i == 8'h23) return 8'h19;
        if (i == 8'h24) return 8'h34;
        if (i == 8'h30 || (i >= int'(BANK_BASE) && i < int'(BANK_BASE) + BANK_REGS))
            return (s < NUM_LDN) ? pat(s, i) : 8'h00;
        return 8'h00;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(logic a, logic [7:0] d);
        io_addr  = a;
        io_wdata = d;
        io_wr    = 1'b1;
        @(negedge clk);
        io_wr    = 1'b0;
    endtask

    task automatic bus_rd(logic a, output logic [7:0] v);
        io_addr = a;
        io_rd   = 1'b1;
        @(negedge clk);
        io_rd   = 1'b0;
        v       = io_rdata;
    endtask

    task automatic unlock();
        bus_wr(1'b0, 8'h87);
        bus_wr(1'b0, 8'h87);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        chk("R1 rdata after reset", io_rdata, 8'hFF);
        chk("R1 wdg_enable after reset", wdg_enable, 0);
        chk("R1 wdg_regs after reset", wdg_regs, 0);
        bus_rd(1'b1, v); chk("R1 locked data read", v, 8'hFF);
        bus_rd(1'b0, v); chk("R4 locked index read", v, 8'hFF);

        // Point index at select, lock, attempt a write while locked
        unlock();
        bus_wr(1'b0, 8'h07);
        bus_rd(1'b1, v); chk("R1 select reset value", v, 8'h00);
        bus_wr(1'b0, 8'hAA);
        bus_rd(1'b1, v); chk("R3 read after exit key", v, 8'hFF);
        bus_rd(1'b0, v); chk("R3 index read after exit key", v, 8'hFF);
        bus_wr(1'b1, 8'h05);
        bus_wr(1'b0, 8'h24);
        unlock();
        bus_rd(1'b0, v); chk("R3 index kept across lock", v, 8'h07);
        bus_rd(1'b1, v); chk("R4 locked write ignored", v, 8'h00);

        // Single key and broken sequences
        bus_wr(1'b0, 8'hAA);
        bus_wr(1'b0, 8'h87);
        bus_rd(1'b1, v); chk("R2 single key stays closed", v, 8'hFF);
        bus_wr(1'b0, 8'h11);
        bus_wr(1'b0, 8'h87);
        bus_rd(1'b1, v); chk("R2 other index write disarms", v, 8'hFF);
        bus_wr(1'b1, 8'h33);
        bus_wr(1'b0, 8'h87);
        bus_rd(1'b1, v); chk("R2 data write disarms", v, 8'hFF);
        bus_wr(1'b0, 8'h87);
        bus_rd(1'b0, v); chk("R2 second key opens", v, 8'h07);
        bus_rd(1'b1, v); chk("R4 data write while armed ignored", v, 8'h00);

        // Index port readback and hold
        bus_wr(1'b0, 8'h5C);
        bus_rd(1'b0, v); chk("R5 index port readback", v, 8'h5C);
        bus_wr(1'b0, 8'h23);
        bus_rd(1'b1, v);
        repeat (3) @(negedge clk);
        chk("R5 read data holds", io_rdata, 8'h19);

        // Write sweep over all register numbers for several selects
        for (int s = 0; s < NSEL; s++) begin
            bus_wr(1'b0, 8'h07);
            bus_wr(1'b1, 8'(s));
            for (int i = 0; i < 256; i++) begin
                if (i == 8'h07 || i == 8'hAA) continue;
                bus_wr(1'b0, 8'(i));
                bus_wr(1'b1, pat(s, i));
            end
        end

        // Read sweep: R6 select, R7 IDs, R8 banking, R9 unimplemented
        for (int s = 0; s < NSEL; s++) begin
            bus_wr(1'b0, 8'h07);
            bus_wr(1'b1, 8'(s));
            for (int i = 0; i < 256; i++) begin
                if (i == 8'hAA) continue;
                bus_wr(1'b0, 8'(i));
                bus_rd(1'b1, v);
                if (i == 8'h07)
                    chk("R6 select readback", v, expect_reg(s, i));
                else if (i >= 8'h20 && i <= 8'h24)
                    chk("R7 id register", v, expect_reg(s, i));
                else if (i == 8'h30 || (i >= int'(BANK_BASE) && i < int'(BANK_BASE) + BANK_REGS))
                    chk("R8 banked register", v, expect_reg(s, i));
                else
                    chk("R9 unimplemented register", v, expect_reg(s, i));
            end
        end

        // Watchdog exposure
        chk("R10 wdg_enable from sweep", wdg_enable, pat(WDG_LDN, 8'h30) & 8'h01);
        for (int k = 0; k < BANK_REGS; k++)
            chk("R10 wdg_regs byte", wdg_regs[8*k +: 8], pat(WDG_LDN, int'(BANK_BASE) + k));
        bus_wr(1'b0, 8'h07);
        bus_wr(1'b1, 8'(WDG_LDN));
        bus_wr(1'b0, 8'h30);
        bus_wr(1'b1, 8'h00);
        chk("R10 wdg_enable cleared", wdg_enable, 0);
        bus_wr(1'b1, 8'h01);
        chk("R10 wdg_enable set", wdg_enable, 1);
        bus_wr(1'b0, BANK_BASE + 8'd1);
        bus_wr(1'b1, 8'hC3);
        chk("R10 wdg_regs byte 1 update", wdg_regs[15:8], 8'hC3);
        bus_wr(1'b0, 8'h07);
        bus_wr(1'b1, 8'd3);
        bus_wr(1'b0, 8'h30);
        bus_wr(1'b1, 8'h00);
        chk("R8 other device leaves watchdog", wdg_enable, 1);
        bus_wr(1'b0, 8'hAA);
        repeat (2) @(negedge clk);
        chk("R10 enable held while locked", wdg_enable, 1);
        chk("R10 regs held while locked", wdg_regs[15:8], 8'hC3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule